// File: doc/BRIEF.md
# Elapsed-Time Counter with Compare Alarm

This block keeps a 48-bit count of ticks from a 32.768 kHz time base. Each tick arrives as a one-clock enable pulse on `tick`. Software reads and writes the count through a 16-bit register port as three words. Because the tick rate is 2^15 per second, the lower 15 bits of the count are a sub-second fraction. The whole-second value is `high<<17 | mid<<1 | low>>15`. The 33-bit seconds range this gives is enough for about 272 years.

A second 48-bit register, also made of three words, holds a compare value. When the count takes on a new value equal to the compare value, an alarm flag is set in a small interrupt status register. Software clears the flag by writing a one to it. The `irq` output is the OR of every status bit ANDed with its enable bit on `irq_en`.

The word reads are not latched together. Software that wants a coherent 48-bit value reads all three words twice and repeats until both passes agree.

Requests arrive on a valid/ready channel. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is waiting and `rsp_ready` is low, so a stalled response blocks further requests. Every accepted read produces exactly one response on the valid/ready response channel, one cycle later. Writes produce no response.

Top module: `elapsed_alarm_timer`

## Requirements
- R1: After reset, the count, the compare value and the status register are zero, `irq` is low, `rsp_valid` is low and `req_ready` is high.
- R2: A `tick` pulse advances the 48-bit count by one in the next cycle. Without a tick or a count write, the count holds its value.
- R3: The count words sit at byte addresses 0x00 (bits 15:0), 0x02 (bits 31:16) and 0x04 (bits 47:32). After 32768 ticks from zero, the low word reads 0x8000, so bit 15 of the low word is the one-second bit.
- R4: A write to one count word changes only that word. A tick in the same cycle as a count-word write is dropped.
- R5: The compare words sit at 0x08, 0x0A and 0x0C with the same bit order, and they read back as written.
- R6: Status bit 0 (the alarm flag, status word at 0x1E) is set two cycles after an accepted tick or count write that moves the count onto the compare value. Writing the compare value so that it equals the present count does not set the flag. A zero compare value after reset does not set the flag until the count changes back to zero.
- R7: Writing a status word with bit 0 at one clears the alarm flag, and writing zero there leaves it unchanged. A new match in the same cycle as a clear wins, and the flag stays set.
- R8: `irq` equals the OR over all status bits of (status bit AND `irq_en` bit). Status bits 15:1 read as zero.
- R9: Each word read returns the word's value at the accepting edge. Reads of different words are not latched together, so a carry between two reads shows a mix of old and new words.
- R10: The read response comes one cycle after acceptance and carries the word's value at the accepting edge. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold their values and `req_ready` is low.
- R11: The count wraps from 2^48-1 to zero, and a zero compare value then raises the alarm flag.
- R12: Reads of unmapped addresses return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at 32.768 kHz |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte address (bit 0 ignored) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_rdata | output | 16 | Read response data |
| irq_en | input | 4 | Per-status-bit interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count shows up in the very next read of a count word. A lost tick or a tick that was not dropped during a write changes that word by one. A wrong match or flag state shows on `irq` within two cycles of the count change, and on a status read one cycle after that. A stuck response register shows in the first stalled response, either as data that changes while `rsp_ready` is low or as `req_ready` staying high during the stall.

// File: rtl/etc_pkg.sv
package etc_pkg;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned ALARM_BIT = 0;

  typedef enum logic [1:0] {
    RG_CNT  = 2'd0,
    RG_CMP  = 2'd1,
    RG_STAT = 2'd2,
    RG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/etc_decode.sv
module etc_decode
  import etc_pkg::*;
#(
  parameter int unsigned NWORD = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  word
);
  logic in_range;

  always_comb begin
    word     = IDX_W'(addr[ADDR_W-2:1]);
    in_range = int'(addr[2:1]) < int'(NWORD);
    if (addr[4:3] == 2'b00 && in_range)      region = RG_CNT;
    else if (addr[4:3] == 2'b01 && in_range) region = RG_CMP;
    else if (addr[4:1] == 4'hF)              region = RG_STAT;
    else                                     region = RG_NONE;
  end
endmodule

// File: rtl/etc_counter.sv
module etc_counter #(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned NWORD = CNT_W / WORD_W,
  localparam int unsigned IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_word,
  input  logic [WORD_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              changed
);
  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = count;
    if (wr_en) begin
      for (int w = 0; w < int'(NWORD); w++)
        if (wr_word == IDX_W'(w)) nxt[w*WORD_W +: WORD_W] = wr_data;
    end else if (tick) begin
      nxt = count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      changed <= 1'b0;
    end else begin
      count   <= nxt;
      changed <= wr_en | tick;
    end
  end
endmodule

// File: rtl/etc_compare.sv
module etc_compare #(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned NWORD = CNT_W / WORD_W,
  localparam int unsigned IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  count,
  input  logic              cnt_changed,
  output logic [CNT_W-1:0]  cmp,
  output logic              hit
);
  genvar g;
  generate
    for (g = 0; g < NWORD; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n)
          cmp[g*WORD_W +: WORD_W] <= '0;
        else if (wr_en && wr_word == IDX_W'(g))
          cmp[g*WORD_W +: WORD_W] <= wr_data;
      end
    end
  endgenerate

  assign hit = cnt_changed && (count == cmp);
endmodule

// File: rtl/etc_status.sv
module etc_status #(
  parameter int unsigned STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] clr_vec,
  input  logic [STAT_W-1:0] en_vec,
  output logic [STAT_W-1:0] flags,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= set_vec | (flags & ~clr_vec);
  end

  assign irq = |(flags & en_vec);
endmodule

// File: rtl/elapsed_alarm_timer.sv
module elapsed_alarm_timer
  import etc_pkg::*;
#(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned STAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  input  logic [STAT_W-1:0] irq_en,
  output logic              irq
);
  localparam int unsigned NWORD = CNT_W / WORD_W;
  localparam int unsigned IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1;

  region_e            region;
  logic [IDX_W-1:0]   word;
  logic               accept, cnt_wr, cmp_wr;
  logic [CNT_W-1:0]   count_q, cmp_q;
  logic               cnt_changed, alarm_hit;
  logic [STAT_W-1:0]  flags, set_vec, clr_vec;
  logic [WORD_W-1:0]  rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign cnt_wr    = accept && req_write && region == RG_CNT;
  assign cmp_wr    = accept && req_write && region == RG_CMP;

  etc_decode #(.NWORD(NWORD), .IDX_W(IDX_W)) u_dec (
    .addr(req_addr), .region(region), .word(word)
  );

  etc_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(cnt_wr), .wr_word(word),
    .wr_data(req_wdata), .count(count_q), .changed(cnt_changed)
  );

  etc_compare #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr_en(cmp_wr), .wr_word(word),
    .wr_data(req_wdata), .count(count_q), .cnt_changed(cnt_changed),
    .cmp(cmp_q), .hit(alarm_hit)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[ALARM_BIT] = alarm_hit;
    clr_vec = (accept && req_write && region == RG_STAT) ? req_wdata[STAT_W-1:0] : '0;
  end

  etc_status #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .en_vec(irq_en), .flags(flags), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (region)
      RG_CNT:
        for (int w = 0; w < int'(NWORD); w++)
          if (word == IDX_W'(w)) rd_mux = count_q[w*WORD_W +: WORD_W];
      RG_CMP:
        for (int w = 0; w < int'(NWORD); w++)
          if (word == IDX_W'(w)) rd_mux = cmp_q[w*WORD_W +: WORD_W];
      RG_STAT: rd_mux = WORD_W'(flags);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/etc_checker.sv
module etc_checker #(
  parameter int unsigned CNT_W  = 48,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned STAT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [WORD_W-1:0] rsp_rdata,
  input logic [CNT_W-1:0]  count_q,
  input logic              cnt_wr,
  input logic              alarm_hit,
  input logic [STAT_W-1:0] flags,
  input logic [STAT_W-1:0] clr_vec
);
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  p_req_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_tick_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cnt_wr |=> count_q == $past(count_q) + CNT_W'(1));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_wr |=> $stable(count_q));

  p_alarm_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> flags[0]);

  p_alarm_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[0] && !alarm_hit |=> !flags[0]);

  p_alarm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vec[0] && !alarm_hit |=> !flags[0]);

  p_alarm_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] && !clr_vec[0] |=> flags[0]);
endmodule

bind elapsed_alarm_timer etc_checker #(.CNT_W(CNT_W), .WORD_W(WORD_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .count_q(count_q), .cnt_wr(cnt_wr), .alarm_hit(alarm_hit),
  .flags(flags), .clr_vec(clr_vec)
);

// File: tb/tb_elapsed_alarm_timer.sv
module tb_elapsed_alarm_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  irq_en = 4'hF;
  logic        req_ready, rsp_valid, irq;
  logic [15:0] rsp_rdata;

  int n_chk = 0, n_bad = 0;

  logic [47:0] m_cnt = '0, m_cmp = '0;
  logic        m_flag = 1'b0, m_chg = 1'b0, m_rv = 1'b0;
  logic [15:0] m_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  elapsed_alarm_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .irq_en(irq_en), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] a);
    if (a[4:3] == 2'b00 && a[2:1] < 2'd3) return "R3";
    if (a[4:3] == 2'b01 && a[2:1] < 2'd3) return "R5";
    if (a[4:1] == 4'hF) return "R6";
    return "R12";
  endfunction

  function automatic logic [15:0] mread(input logic [4:0] a);
    int i;
    i = int'(a[2:1]);
    if (a[4:3] == 2'b00 && i < 3) return m_cnt[i*16 +: 16];
    if (a[4:3] == 2'b01 && i < 3) return m_cmp[i*16 +: 16];
    if (a[4:1] == 4'hF) return {15'b0, m_flag};
    return 16'h0;
  endfunction

  // one clock: drive at negedge, update model at posedge, check at next negedge
  task automatic cyc(input logic t, input logic v, input logic w, input logic [4:0] a,
                     input logic [15:0] d, input logic rr);
    logic        rdy, acc, chg, nf, nrv;
    logic [47:0] nc, ncmp;
    logic [15:0] nrd;
    int          i;
    tick = t; req_valid = v; req_write = w; req_addr = a; req_wdata = d; rsp_ready = rr;
    #1;
    rdy = !m_rv || rr;
    chk(req_ready == rdy, "R10", 64'(req_ready), 64'(rdy));
    acc = v && rdy;
    i = int'(a[2:1]);
    nc = m_cnt; chg = 1'b0; ncmp = m_cmp;
    if (acc && w && a[4:3] == 2'b00 && i < 3) begin nc[i*16 +: 16] = d; chg = 1'b1; end
    else if (t) begin nc = m_cnt + 48'd1; chg = 1'b1; end
    if (acc && w && a[4:3] == 2'b01 && i < 3) ncmp[i*16 +: 16] = d;
    nf = (m_chg && m_cnt == m_cmp) | (m_flag & ~(acc && w && a[4:1] == 4'hF && d[0]));
    nrv = m_rv; nrd = m_rd;
    if (acc && !w) begin nrv = 1'b1; nrd = mread(a); end
    else if (rr) nrv = 1'b0;
    @(posedge clk);
    m_cnt = nc; m_chg = chg; m_cmp = ncmp; m_flag = nf; m_rv = nrv; m_rd = nrd;
    @(negedge clk);
    chk(rsp_valid == m_rv, "R10", 64'(rsp_valid), 64'(m_rv));
    if (m_rv) chk(rsp_rdata == m_rd, tag_of(a), 64'(rsp_rdata), 64'(m_rd));
    chk(irq == (m_flag & irq_en[0]), "R8", 64'(irq), 64'(m_flag & irq_en[0]));
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] q);
    cyc(1'b0, 1'b1, 1'b0, a, 16'h0, 1'b1);
    q = rsp_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    cyc(1'b0, 1'b1, 1'b1, a, d, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 1'b0, 5'h0, 16'h0, 1'b1);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 1'b0, 5'h0, 16'h0, 1'b1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] q, q2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1", 64'(rsp_valid), 0);
    chk(irq == 1'b0, "R1", 64'(irq), 0);
    chk(req_ready == 1'b1, "R1", 64'(req_ready), 1);
    rd(5'h00, q); chk(q == 16'h0, "R1", 64'(q), 0);
    rd(5'h04, q); chk(q == 16'h0, "R1", 64'(q), 0);
    rd(5'h08, q); chk(q == 16'h0, "R1", 64'(q), 0);
    rd(5'h1E, q); chk(q == 16'h0, "R1", 64'(q), 0);
    // R2 ticks advance; zero compare does not fire on leaving zero (R6)
    ticks(5); idle(2);
    rd(5'h00, q); chk(q == 16'd5, "R2", 64'(q), 5);
    idle(3);
    rd(5'h00, q); chk(q == 16'd5, "R2", 64'(q), 5);
    rd(5'h1E, q); chk(q == 16'h0, "R6", 64'(q), 0);
    // write low to zero -> count equals zero compare -> flag (R6)
    wr(5'h00, 16'h0); idle(1);
    rd(5'h1E, q); chk(q == 16'h1, "R6", 64'(q), 1);
    // R7 clear semantics
    wr(5'h1E, 16'h0000); idle(1);
    rd(5'h1E, q); chk(q == 16'h1, "R7", 64'(q), 1);
    wr(5'h1E, 16'h0001); idle(1);
    rd(5'h1E, q); chk(q == 16'h0, "R7", 64'(q), 0);
    // R3 one-second bit
    ticks(32768);
    rd(5'h00, q); chk(q == 16'h8000, "R3", 64'(q), 64'h8000);
    rd(5'h02, q); chk(q == 16'h0, "R3", 64'(q), 0);
    ticks(32768);
    rd(5'h00, q); chk(q == 16'h0, "R3", 64'(q), 0);
    rd(5'h02, q); chk(q == 16'h1, "R3", 64'(q), 1);
    wr(5'h1E, 16'h0001);
    // R4 word write with coincident tick
    cyc(1'b1, 1'b1, 1'b1, 5'h02, 16'h1234, 1'b1);
    rd(5'h00, q); chk(q == 16'h0, "R4", 64'(q), 0);
    rd(5'h02, q); chk(q == 16'h1234, "R4", 64'(q), 64'h1234);
    rd(5'h04, q); chk(q == 16'h0, "R4", 64'(q), 0);
    // R5 compare words
    wr(5'h08, 16'hAAAA); wr(5'h0A, 16'h5555); wr(5'h0C, 16'h0F0F);
    rd(5'h08, q); chk(q == 16'hAAAA, "R5", 64'(q), 64'hAAAA);
    rd(5'h0A, q); chk(q == 16'h5555, "R5", 64'(q), 64'h5555);
    rd(5'h0C, q); chk(q == 16'h0F0F, "R5", 64'(q), 64'h0F0F);
    // R6 tick onto compare
    wr(5'h00, 16'hAAA9); wr(5'h02, 16'h5555); wr(5'h04, 16'h0F0F);
    wr(5'h1E, 16'h0001); idle(2);
    rd(5'h1E, q); chk(q == 16'h0, "R6", 64'(q), 0);
    ticks(1); idle(1);
    chk(irq == 1'b1, "R8", 64'(irq), 1);
    rd(5'h1E, q); chk(q == 16'h1, "R6", 64'(q), 1);
    irq_en = 4'hE; idle(1);
    chk(irq == 1'b0, "R8", 64'(irq), 0);
    irq_en = 4'hF;
    wr(5'h1E, 16'hFFFF);
    // R6 compare written equal to count: no flag
    wr(5'h08, 16'hAAAA); idle(2);
    rd(5'h1E, q); chk(q == 16'h0, "R6", 64'(q), 0);
    // R12 unmapped
    rd(5'h10, q); chk(q == 16'h0, "R12", 64'(q), 0);
    wr(5'h10, 16'hFFFF); wr(5'h16, 16'hFFFF);
    rd(5'h10, q); chk(q == 16'h0, "R12", 64'(q), 0);
    rd(5'h00, q); chk(q == 16'hAAAA, "R12", 64'(q), 64'hAAAA);
    // R9 torn read across carry
    wr(5'h00, 16'hFFFF); wr(5'h02, 16'h0000);
    rd(5'h00, q); ticks(1); rd(5'h02, q2);
    chk(q == 16'hFFFF && q2 == 16'h0001, "R9", 64'({q, q2}), 64'hFFFF0001);
    // R11 wrap with zero compare
    wr(5'h08, 16'h0); wr(5'h0A, 16'h0); wr(5'h0C, 16'h0);
    wr(5'h04, 16'hFFFF); wr(5'h02, 16'hFFFF); wr(5'h00, 16'hFFFF);
    wr(5'h1E, 16'h0001);
    ticks(1); idle(1);
    rd(5'h1E, q); chk(q == 16'h1, "R11", 64'(q), 1);
    rd(5'h04, q); chk(q == 16'h0, "R11", 64'(q), 0);
    rd(5'h00, q); chk(q == 16'h1 || q == 16'h0, "R11", 64'(q), 0);
    // R10 back-pressure
    idle(1);
    cyc(1'b0, 1'b1, 1'b0, 5'h1E, 16'h0, 1'b0);
    q = rsp_rdata;
    cyc(1'b0, 1'b1, 1'b0, 5'h08, 16'h0, 1'b0);
    chk(rsp_rdata == q, "R10", 64'(rsp_rdata), 64'(q));
    cyc(1'b0, 1'b0, 1'b0, 5'h00, 16'h0, 1'b1);
    idle(1);
    // random mix
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4000; k++) begin
      logic [4:0] a;
      logic [15:0] d;
      case ($urandom % 9)
        0: a = 5'h00; 1: a = 5'h02; 2: a = 5'h04; 3: a = 5'h08;
        4: a = 5'h0A; 5: a = 5'h0C; 6: a = 5'h1E; 7: a = 5'h10;
        default: a = 5'h18;
      endcase
      d = 16'($urandom);
      if (a == 5'h08 && ($urandom % 2) == 0) d = m_cnt[15:0] + 16'd2;
      if ((k % 500) == 0) irq_en = 4'($urandom);
      cyc(1'($urandom % 2), 1'($urandom % 3 != 0), 1'($urandom % 2), a, d,
          1'($urandom % 4 != 0));
    end
    idle(2);
    summary();
    $finish;
  end
endmodule